// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small 32-bit processor core that fetches, decodes, executes, accesses memory, writes back and updates its program counter in one clock cycle per instruction. It holds a program counter and a 32-entry register file. Each cycle it presents the current program counter to an external instruction memory and receives the instruction word back in the same cycle. Loads and stores reach an external data memory through an address, a write-data bus, a write strobe and a read-data bus. Both memories read combinationally and write on the rising clock edge.

The supported operations are register add, subtract, AND, OR and signed set-less-than; add-immediate; word load and store; branch-if-equal; and an absolute jump. Any other opcode or function code performs no register or memory write and advances the program counter by 4. A program is placed in instruction memory, reset is released, and the program runs from address 0.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset forces the program counter (`imem_addr`) to 0 at the next rising edge, and the register file to all zeros.
- R2: Every instruction except a taken branch and a jump advances `imem_addr` by 4 at the next rising edge.
- R3: Opcode 0x00 (bits 31:26) is a register operation selected by bits 5:0. Function 0x20 adds, 0x22 subtracts (rs minus rt), 0x24 ANDs and 0x25 ORs. Fields are rs at bits 25:21, rt at 20:16 and rd at 15:11, and the result is written to rd.
- R4: Opcode 0x08 writes rs plus the sign-extended bits 15:0 to register rt.
- R5: Opcode 0x23 reads the data word at rs plus the sign-extended bits 15:0 and writes it to register rt.
- R6: Opcode 0x2B raises `dmem_we` with `dmem_addr` equal to rs plus the sign-extended offset and `dmem_wdata` equal to register rt. It writes no register. Only this opcode raises `dmem_we`.
- R7: Opcode 0x04 compares registers rs and rt. When they are equal the next program counter is PC+4 plus the sign-extended offset shifted left by 2; otherwise it is PC+4.
- R8: Opcode 0x02 sets the next program counter to the upper 4 bits of PC+4, followed by bits 25:0 of the instruction and two zero bits.
- R9: Register 0 always reads as zero. Writes that target it are discarded.
- R10: Function 0x2A writes 1 to rd when rs is less than rt as signed two's-complement numbers, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (program counter) |
| imem_rdata | input | 32 | Instruction word, read combinationally |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, written at the rising edge |
| dmem_rdata | input | 32 | Load data, read combinationally |

## Verification
The bench builds the core with its default 32-bit data width and 5-bit register index. It sweeps every ordered pair from an eight-value operand set, 64 programs in all. The set covers zero, one, all ones, the most negative and most positive values and mixed patterns. Each program pulls its operands from data memory, runs every arithmetic operation, an add-immediate, a write to register 0 and a branch whose direction depends on the pair, and stores all results back. The bench predicts each stored result arithmetically, including signed-compare sign crossings, carries out of bit 31 and equal pairs that take the branch. A final loop program summing 0 through 9 exercises backward jumps and a branch that exits the loop.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    typedef enum logic [5:0] {
        OPC_REG   = 6'h00,
        OPC_JMP   = 6'h02,
        OPC_BEQ   = 6'h04,
        OPC_ADDI  = 6'h08,
        OPC_LOAD  = 6'h23,
        OPC_STORE = 6'h2B
    } opcode_e;

    typedef enum logic [5:0] {
        FN_ADD = 6'h20,
        FN_SUB = 6'h22,
        FN_AND = 6'h24,
        FN_OR  = 6'h25,
        FN_SLT = 6'h2A
    } func_e;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;
        logic    dst_is_rd;
        logic    src_is_imm;
        logic    is_branch;
        logic    is_jump;
        logic    mem_we;
        logic    load_to_reg;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        case (opcode)
            OPC_REG: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_we    = 1'b1;
                case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl.reg_we = 1'b0;
                endcase
            end
            OPC_ADDI: begin
                ctrl.reg_we     = 1'b1;
                ctrl.src_is_imm = 1'b1;
            end
            OPC_LOAD: begin
                ctrl.reg_we      = 1'b1;
                ctrl.src_is_imm  = 1'b1;
                ctrl.load_to_reg = 1'b1;
            end
            OPC_STORE: begin
                ctrl.mem_we     = 1'b1;
                ctrl.src_is_imm = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            OPC_JMP: ctrl.is_jump = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y,
    output logic             zero
);
    always_comb begin
        case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int WIDTH = 32,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [WIDTH-1:0] rdata_a,
    output logic [WIDTH-1:0] rdata_b,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [WIDTH-1:0] wdata
);
    localparam int NREG = 1 << AW;

    logic [NREG-1:0][WIDTH-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we && (waddr != '0)) regs_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (we && waddr != '0) |=> regs_q[$past(waddr)] == $past(wdata)); // R3
    AST_ZERO_REG_HELD: assert property (@(posedge clk) disable iff (rst)
        (we && waddr == '0) |=> regs_q[0] == '0); // R9
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int REG_AW = 5
) (
    input  logic             clk,
    input  logic             rst,
    output logic [WIDTH-1:0] imem_addr,
    input  logic [WIDTH-1:0] imem_rdata,
    output logic [WIDTH-1:0] dmem_addr,
    output logic [WIDTH-1:0] dmem_wdata,
    output logic             dmem_we,
    input  logic [WIDTH-1:0] dmem_rdata
);
    localparam int IMM_W = 16;
    localparam int TGT_W = 26;
    localparam int HI_W  = WIDTH - TGT_W - 2;

    typedef struct packed {
        logic [WIDTH-1:0] pc;
    } state_t;

    state_t state_d, state_q;

    ctrl_t             ctrl;
    logic [REG_AW-1:0] rs_idx, rt_idx, rd_idx, wr_idx;
    logic [WIDTH-1:0]  rs_val, rt_val, imm_ext, alu_b, alu_y, wb_val;
    logic [WIDTH-1:0]  pc_plus4, br_target, jmp_target;
    logic              alu_zero, rf_we;

    assign rs_idx = imem_rdata[25:21];
    assign rt_idx = imem_rdata[20:16];
    assign rd_idx = imem_rdata[15:11];

    sc_decoder u_dec (
        .opcode (imem_rdata[31:26]),
        .funct  (imem_rdata[5:0]),
        .ctrl   (ctrl)
    );

    sc_regfile #(.WIDTH(WIDTH), .AW(REG_AW)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .raddr_a (rs_idx),
        .raddr_b (rt_idx),
        .rdata_a (rs_val),
        .rdata_b (rt_val),
        .we      (rf_we),
        .waddr   (wr_idx),
        .wdata   (wb_val)
    );

    sc_alu #(.WIDTH(WIDTH)) u_alu (
        .op   (ctrl.alu_op),
        .a    (rs_val),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    always_comb begin
        imm_ext    = {{(WIDTH-IMM_W){imem_rdata[IMM_W-1]}}, imem_rdata[IMM_W-1:0]};
        alu_b      = ctrl.src_is_imm ? imm_ext : rt_val;
        wr_idx     = ctrl.dst_is_rd ? rd_idx : rt_idx;
        wb_val     = ctrl.load_to_reg ? dmem_rdata : alu_y;
        rf_we      = ctrl.reg_we;
        pc_plus4   = state_q.pc + WIDTH'(4);
        br_target  = pc_plus4 + {imm_ext[WIDTH-3:0], 2'b00};
        jmp_target = {pc_plus4[WIDTH-1 -: HI_W], imem_rdata[TGT_W-1:0], 2'b00};

        state_d = state_q;
        if (ctrl.is_jump)                    state_d.pc = jmp_target;
        else if (ctrl.is_branch && alu_zero) state_d.pc = br_target;
        else                                 state_d.pc = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign imem_addr  = state_q.pc;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_we;

    AST_RESET_PC: assert property (@(posedge clk)
        rst |=> state_q.pc == '0); // R1
    AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.is_branch && !ctrl.is_jump) |=> state_q.pc == $past(state_q.pc) + WIDTH'(4)); // R2
    AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (ctrl.is_branch && rs_val == rt_val) |=> state_q.pc == $past(br_target)); // R7
    AST_BEQ_FALL: assert property (@(posedge clk) disable iff (rst)
        (ctrl.is_branch && rs_val != rt_val) |=> state_q.pc == $past(state_q.pc) + WIDTH'(4)); // R7
    AST_JUMP_PC: assert property (@(posedge clk) disable iff (rst)
        ctrl.is_jump |=> state_q.pc[TGT_W+1:0] == {$past(imem_rdata[TGT_W-1:0]), 2'b00}); // R8
    AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> !rf_we); // R6
endmodule

// File: tb/tb_sc_core.sv
module tb_sc_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    sc_core dut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    function automatic logic [31:0] rop(input logic [5:0] fn, input int rd, input int rs, input int rt);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] iop(input logic [5:0] op, input int rt, input int rs, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] jop(input int word_idx);
        return {6'h02, 26'(word_idx)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'h0;
            dmem[i] = 32'h0;
        end
    endtask

    task automatic apply_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [31:0] op_val(input int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h0000_0007;
            4: return 32'h8000_0000;
            5: return 32'h7FFF_FFFF;
            6: return 32'h1234_5678;
            default: return 32'hFFFF_0000;
        endcase
    endfunction

    task automatic load_sweep_prog();
        imem[0]  = iop(6'h23, 1, 0, 16'd0);      // lw r1
        imem[1]  = iop(6'h23, 2, 0, 16'd4);      // lw r2
        imem[2]  = rop(6'h20, 3, 1, 2);
        imem[3]  = rop(6'h22, 4, 1, 2);
        imem[4]  = rop(6'h24, 5, 1, 2);
        imem[5]  = rop(6'h25, 6, 1, 2);
        imem[6]  = rop(6'h2A, 7, 1, 2);
        imem[7]  = iop(6'h2B, 3, 0, 16'd16);
        imem[8]  = iop(6'h2B, 4, 0, 16'd20);
        imem[9]  = iop(6'h2B, 5, 0, 16'd24);
        imem[10] = iop(6'h2B, 6, 0, 16'd28);
        imem[11] = iop(6'h2B, 7, 0, 16'd32);
        imem[12] = iop(6'h08, 8, 1, 16'hFFFB);   // addi r8, r1, -5
        imem[13] = iop(6'h2B, 8, 0, 16'd36);
        imem[14] = rop(6'h20, 0, 1, 2);          // write to r0
        imem[15] = iop(6'h2B, 0, 0, 16'd40);
        imem[16] = iop(6'h04, 2, 1, 16'd1);      // beq r1, r2, skip 1
        imem[17] = iop(6'h08, 9, 0, 16'd1);
        imem[18] = iop(6'h08, 10, 0, 16'd2);
        imem[19] = iop(6'h2B, 9, 0, 16'd44);
        imem[20] = iop(6'h2B, 10, 0, 16'd48);
        imem[21] = jop(21);
    endtask

    initial begin
        clear_mem();
        @(negedge clk);
        // Operand sweep
        for (int ia = 0; ia < 8; ia++) begin
            for (int ib = 0; ib < 8; ib++) begin
                logic [31:0] a, b;
                a = op_val(ia);
                b = op_val(ib);
                rst = 1'b1;
                clear_mem();
                load_sweep_prog();
                dmem[0]  = a;
                dmem[1]  = b;
                dmem[10] = 32'h5555_5555;
                dmem[15] = 32'hDEAD_BEEF;
                apply_reset();
                if (ia == 0 && ib == 0) begin
                    check("R1 pc after reset", imem_addr, 32'h0);
                    @(negedge clk);
                    check("R2 pc step 1", imem_addr, 32'h4);
                    @(negedge clk);
                    check("R2 pc step 2", imem_addr, 32'h8);
                end
                repeat (30) @(negedge clk);
                check("R3 add",        dmem[4], a + b);
                check("R3 sub",        dmem[5], a - b);
                check("R3 and",        dmem[6], a & b);
                check("R3 or",         dmem[7], a | b);
                check("R10 slt",       dmem[8], {31'd0, $signed(a) < $signed(b)});
                check("R4 addi",       dmem[9], a - 32'd5);
                check("R9 r0 zero",    dmem[10], 32'h0);
                check("R7 beq",        dmem[11], (a == b) ? 32'h0 : 32'h1);
                check("R7 fallthru",   dmem[12], 32'h2);
                check("R5 lw operand", dmem[0], a);
                check("R6 sentinel",   dmem[15], 32'hDEAD_BEEF);
                check("R8 jump hold",  imem_addr, 32'd84);
            end
        end

        // Loop summing 0..9
        rst = 1'b1;
        clear_mem();
        imem[0] = iop(6'h08, 17, 0, 16'd0);
        imem[1] = rop(6'h20, 16, 0, 0);
        imem[2] = iop(6'h08, 8, 0, 16'd10);
        imem[3] = iop(6'h04, 8, 16, 16'd3);      // beq r16, r8 -> 7
        imem[4] = rop(6'h20, 17, 17, 16);
        imem[5] = iop(6'h08, 16, 16, 16'd1);
        imem[6] = jop(3);
        imem[7] = iop(6'h2B, 17, 0, 16'd0);
        imem[8] = iop(6'h2B, 16, 0, 16'd4);
        imem[9] = jop(9);
        apply_reset();
        repeat (80) @(negedge clk);
        check("R7 loop sum", dmem[0], 32'd45);
        check("R7 loop idx", dmem[1], 32'd10);
        check("R8 loop end", imem_addr, 32'd36);

        // Reset mid-run returns pc to 0
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-run", imem_addr, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule